// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table kept in a synchronous single-port memory. A requester presents the logical address together with the byte address of the top-level table. The walker fetches the top-level entry, uses it to locate the second-level table, fetches the second-level entry, and answers with either the physical address or a fault that names the level at which the walk stopped.

The logical address has a fixed split: bits [31:22] select the top-level entry, bits [21:12] select the second-level entry, and bits [11:0] are the byte offset inside a 4 KB page. Every table entry is one 32-bit word: bit 0 is the valid flag and bits [31:12] hold a 4 KB frame number, which is either the base of the next table or the final page frame. Bits [11:1] of an entry carry no meaning for the walk. The entry for index i of a table whose base frame is F sits at byte address F*4096 + i*4, that is at memory word address F*1024 + i. The memory returns read data one cycle after a read strobe. Only one walk is in flight at a time; the requester sees a valid/ready handshake on each side.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, busy, rsp_valid and mem_rd_en are 0.
- R2: In the cycle after a request is accepted (req_valid and req_ready high at a clock edge), mem_rd_en is 1 with mem_rd_addr = req_root[31:12]*1024 + req_vaddr[31:22]; bits [11:0] of req_root are ignored.
- R3: When the top-level entry has bit 0 = 1, a second read is issued two cycles after the first, at word address entry[31:12]*1024 + vaddr[21:12]; entry bits [11:1] have no effect.
- R4: When the second-level entry has bit 0 = 1, rsp_valid rises two cycles after the second read with rsp_fault = 0 and rsp_paddr = {entry[31:12], vaddr[11:0]}.
- R5: When the top-level entry has bit 0 = 0, no second read is issued and rsp_valid rises two cycles after the first read with rsp_fault = 1, rsp_fault_lvl = 0 and rsp_paddr = 0.
- R6: When the second-level entry has bit 0 = 0, rsp_valid rises two cycles after the second read with rsp_fault = 1, rsp_fault_lvl = 1 and rsp_paddr = 0.
- R7: While rsp_valid is 1 and rsp_ready is 0, the response fields stay unchanged; after the edge where both are 1, rsp_valid is 0 and the walker is idle again.
- R8: busy is 1 and req_ready is 0 from the cycle after acceptance through the cycle of the response handshake.
- R9: A request presented while busy is 1 is not accepted and does not alter the walk in progress or its response.
- R10: Each read strobe lasts exactly one cycle, and no read is issued while idle or while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_root | input | 32 | Byte address of the top-level table (4 KB aligned, low bits ignored) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | 1 when the walk met an invalid entry |
| rsp_fault_lvl | output | 1 | Level of the invalid entry: 0 top, 1 second |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| busy | output | 1 | A walk or its response is in progress |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_rd_addr | output | 30 | Table memory word address |
| mem_rd_data | input | 32 | Table memory data, valid one cycle after the strobe |

## Verification
Counting edges from the acceptance edge, the first read strobe is due in the first cycle, the second read in the third, a top-level fault response in the third and every other response in the fifth, held until the response handshake edge. The bench keeps an edge counter per walk in a behavioural model, derives from it what each output must be in every cycle, and compares all outputs at the falling edge, so every result is checked in exactly the cycle it is due and also checked absent in every other cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int VA_W     = 32;
    localparam int OFS_W    = 12;
    localparam int IDX_W    = 10;
    localparam int FRAME_W  = VA_W - OFS_W;
    localparam int ENTRY_W  = 32;
    localparam int WORD_AW  = VA_W - 2;
    localparam int VALID_BIT = 0;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_READ_OUTER,
        WS_READ_INNER,
        WS_DONE,
        WS_FAULT
    } walk_state_e;

    typedef struct packed {
        walk_state_e          state;
        logic                 rd_wait;
        logic [VA_W-1:0]      vaddr;
        logic [FRAME_W-1:0]   root_frame;
        logic [FRAME_W-1:0]   next_frame;
        logic [VA_W-1:0]      paddr;
        logic                 flt_lvl;
    } walk_regs_t;

endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr
    import pt_walker_pkg::*;
#(
    parameter int P_VA_W    = VA_W,
    parameter int P_OFS_W   = OFS_W,
    parameter int P_IDX_W   = IDX_W,
    parameter int P_WORD_AW = WORD_AW
) (
    input  logic                          second_lvl,
    input  logic [P_VA_W-1:0]             vaddr,
    input  logic [P_VA_W-P_OFS_W-1:0]     root_frame,
    input  logic [P_VA_W-P_OFS_W-1:0]     next_frame,
    output logic [P_WORD_AW-1:0]          word_addr
);
    localparam int L_FRAME_W   = P_VA_W - P_OFS_W;
    localparam int L_WORD_SH   = P_OFS_W - 2;
    localparam int L_HI_LSB    = P_OFS_W + P_IDX_W;

    logic [L_FRAME_W-1:0]  tbl_frame;
    logic [P_IDX_W-1:0]    tbl_idx;
    logic [P_WORD_AW-1:0]  tbl_word_base;

    always_comb begin
        tbl_frame     = second_lvl ? next_frame : root_frame;
        tbl_idx       = second_lvl ? vaddr[P_OFS_W +: P_IDX_W]
                                   : vaddr[L_HI_LSB +: P_IDX_W];
        tbl_word_base = {tbl_frame, {L_WORD_SH{1'b0}}};
        word_addr     = tbl_word_base + P_WORD_AW'(tbl_idx);
    end

endmodule

// File: rtl/pt_walker_entry.sv
module pt_walker_entry
    import pt_walker_pkg::*;
#(
    parameter int P_ENTRY_W   = ENTRY_W,
    parameter int P_OFS_W     = OFS_W,
    parameter int P_VALID_BIT = VALID_BIT
) (
    input  logic [P_ENTRY_W-1:0]          entry,
    output logic                          ent_valid,
    output logic [P_ENTRY_W-P_OFS_W-1:0]  ent_frame
);
    generate
        if (P_VALID_BIT < P_OFS_W) begin : g_flag_in_low
            assign ent_valid = entry[P_VALID_BIT];
        end else begin : g_flag_default
            assign ent_valid = entry[0];
        end
    endgenerate

    assign ent_frame = entry[P_ENTRY_W-1:P_OFS_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [VA_W-1:0]     req_root,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic                rsp_fault,
    output logic                rsp_fault_lvl,
    output logic [VA_W-1:0]     rsp_paddr,
    output logic                busy,
    output logic                mem_rd_en,
    output logic [WORD_AW-1:0]  mem_rd_addr,
    input  logic [ENTRY_W-1:0]  mem_rd_data
);

    walk_regs_t r_d;
    walk_regs_t r_q;

    logic                 ent_valid;
    logic [FRAME_W-1:0]   ent_frame;
    logic [WORD_AW-1:0]   tbl_word;
    logic                 at_inner;

    assign at_inner = (r_q.state == WS_READ_INNER);

    pt_walker_addr u_addr (
        .second_lvl (at_inner),
        .vaddr      (r_q.vaddr),
        .root_frame (r_q.root_frame),
        .next_frame (r_q.next_frame),
        .word_addr  (tbl_word)
    );

    pt_walker_entry u_entry (
        .entry     (mem_rd_data),
        .ent_valid (ent_valid),
        .ent_frame (ent_frame)
    );

    always_comb begin
        r_d       = r_q;
        mem_rd_en = 1'b0;
        unique case (r_q.state)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.state      = WS_READ_OUTER;
                    r_d.rd_wait    = 1'b0;
                    r_d.vaddr      = req_vaddr;
                    r_d.root_frame = req_root[VA_W-1:OFS_W];
                    r_d.paddr      = '0;
                    r_d.flt_lvl    = 1'b0;
                end
            end
            WS_READ_OUTER: begin
                if (!r_q.rd_wait) begin
                    mem_rd_en   = 1'b1;
                    r_d.rd_wait = 1'b1;
                end else if (!ent_valid) begin
                    r_d.state   = WS_FAULT;
                    r_d.flt_lvl = 1'b0;
                    r_d.paddr   = '0;
                    r_d.rd_wait = 1'b0;
                end else begin
                    r_d.state      = WS_READ_INNER;
                    r_d.next_frame = ent_frame;
                    r_d.rd_wait    = 1'b0;
                end
            end
            WS_READ_INNER: begin
                if (!r_q.rd_wait) begin
                    mem_rd_en   = 1'b1;
                    r_d.rd_wait = 1'b1;
                end else if (!ent_valid) begin
                    r_d.state   = WS_FAULT;
                    r_d.flt_lvl = 1'b1;
                    r_d.paddr   = '0;
                    r_d.rd_wait = 1'b0;
                end else begin
                    r_d.state   = WS_DONE;
                    r_d.paddr   = {ent_frame, r_q.vaddr[OFS_W-1:0]};
                    r_d.rd_wait = 1'b0;
                end
            end
            WS_DONE, WS_FAULT: begin
                if (rsp_ready) begin
                    r_d.state = WS_IDLE;
                end
            end
            default: begin
                r_d.state = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: WS_IDLE, rd_wait: 1'b0, vaddr: '0, root_frame: '0,
                     next_frame: '0, paddr: '0, flt_lvl: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_addr   = tbl_word;
    assign req_ready     = (r_q.state == WS_IDLE);
    assign busy          = (r_q.state != WS_IDLE);
    assign rsp_valid     = (r_q.state == WS_DONE) || (r_q.state == WS_FAULT);
    assign rsp_fault     = (r_q.state == WS_FAULT);
    assign rsp_fault_lvl = r_q.flt_lvl;
    assign rsp_paddr     = r_q.paddr;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               rsp_fault,
    input logic               rsp_fault_lvl,
    input logic [VA_W-1:0]    rsp_paddr,
    input logic               busy,
    input logic               mem_rd_en
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !rsp_valid)); // R1

    AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R5

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_fault) && $stable(rsp_fault_lvl))); // R7

    AST_HANDSHAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready)); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready && !rsp_valid)); // R8

    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (busy && !req_ready)); // R8

    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R10

    AST_NO_READ_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_rd_en); // R10

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl),
    .rsp_paddr     (rsp_paddr),
    .busy          (busy),
    .mem_rd_en     (mem_rd_en)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic        rsp_fault_lvl;
    logic [31:0] rsp_paddr;
    logic        busy;
    logic        mem_rd_en;
    logic [29:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;

    always #2.5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
        .rsp_paddr(rsp_paddr), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    logic [31:0] tbl [logic [29:0]];

    function automatic logic [31:0] peek(input logic [29:0] a);
        return tbl.exists(a) ? tbl[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= peek(mem_rd_addr);
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: phase 0 idle, 1 walking, 2 answering
    int          m_ph = 0;
    int          m_t  = 0;
    int          m_rsp_t = 0;
    logic [29:0] m_a1, m_a2;
    logic        m_f, m_lvl;
    logic [31:0] m_pa;
    logic        model_on = 1'b0;

    task automatic predict(input logic [31:0] va, input logic [31:0] root);
        logic [31:0] e1, e2;
        m_a1 = 30'(root[31:12]) * 30'd1024 + 30'(va[31:22]);
        e1   = peek(m_a1);
        m_a2 = 30'(e1[31:12]) * 30'd1024 + 30'(va[21:12]);
        if (!e1[0]) begin
            m_f = 1'b1; m_lvl = 1'b0; m_pa = 32'h0; m_rsp_t = 3;
        end else begin
            e2 = peek(m_a2);
            m_rsp_t = 5;
            if (!e2[0]) begin
                m_f = 1'b1; m_lvl = 1'b1; m_pa = 32'h0;
            end else begin
                m_f = 1'b0; m_lvl = 1'b0; m_pa = {e2[31:12], va[11:0]};
            end
        end
    endtask

    always @(posedge clk) begin
        if (model_on) begin
            case (m_ph)
                0: if (req_valid) begin
                    predict(req_vaddr, req_root);
                    m_ph = 1; m_t = 1;
                end
                1: begin
                    m_t++;
                    if (m_t == m_rsp_t) m_ph = 2;
                end
                default: if (rsp_ready) m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            logic exp_en;
            exp_en = (m_ph == 1) && ((m_t == 1) || (m_t == 3 && m_rsp_t == 5));
            chk(m_ph == 0 ? "R1" : "R8", "req_ready", 32'(req_ready), 32'(m_ph == 0));
            chk("R8", "busy", 32'(busy), 32'(m_ph != 0));
            chk(m_rsp_t == 3 ? "R5" : "R4", "rsp_valid", 32'(rsp_valid), 32'(m_ph == 2));
            chk("R10", "mem_rd_en", 32'(mem_rd_en), 32'(exp_en));
            if (exp_en && m_t == 1) chk("R2", "outer addr", 32'(mem_rd_addr), 32'(m_a1));
            if (exp_en && m_t == 3) chk("R3", "inner addr", 32'(mem_rd_addr), 32'(m_a2));
            if (m_ph == 2) begin
                chk(m_f ? (m_lvl ? "R6" : "R5") : "R4", "rsp_fault", 32'(rsp_fault), 32'(m_f));
                if (m_f) chk(m_lvl ? "R6" : "R5", "rsp_fault_lvl", 32'(rsp_fault_lvl), 32'(m_lvl));
                chk(m_f ? "R5" : "R4", "rsp_paddr", rsp_paddr, m_pa);
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [31:0] root, input int stall,
                        input bit poke, input logic [31:0] poke_va);
        @(negedge clk);
        req_vaddr = va; req_root = root; req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_vaddr = poke_va; req_root = 32'h0;  // R9 distractor while busy
        end else begin
            req_valid = 1'b0;
        end
        while (m_ph != 2) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < stall; i++) @(negedge clk);  // R7 held response
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R7", "rsp_valid after handshake", 32'(rsp_valid), 32'h0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // tables
        tbl[30'h4001]     = 32'h0002_0001;   // top idx1 -> frame 0x20
        tbl[30'h8003]     = 32'h1234_5FFF;   // second idx3, junk bits 11:1 (R3)
        tbl[30'h4005]     = 32'h0003_0001;   // top idx5 -> frame 0x30
        tbl[30'hC007]     = 32'h0ABC_D0FE;   // second idx7 invalid
        tbl[30'h3FFF_FFFF]= 32'h0004_0FFF;   // top last index, junk low bits
        tbl[30'h0001_03FF]= 32'hFFFF_F001;   // second last index
        tbl[30'h4000]     = 32'h0005_0001;   // top idx0
        tbl[30'h0001_4000]= 32'h0777_7001;   // second idx0

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready", 32'(req_ready), 32'h1);
        chk("R1", "busy", 32'(busy), 32'h0);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R1", "mem_rd_en", 32'(mem_rd_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;

        walk(32'h0040_3ABC, 32'h0001_0000, 0, 1'b0, 32'h0);  // R4 success
        walk(32'h0080_0123, 32'h0001_0000, 0, 1'b0, 32'h0);  // R5 top invalid
        walk(32'h0140_7FFF, 32'h0001_0000, 2, 1'b0, 32'h0);  // R6 second invalid
        walk(32'hFFFF_FFFF, 32'hFFFF_F000, 0, 1'b0, 32'h0);  // R2 R3 last indices
        walk(32'h0000_0000, 32'h0001_0ABC, 0, 1'b0, 32'h0);  // R2 low root bits ignored
        walk(32'h0040_3001, 32'h0001_0000, 4, 1'b1, 32'h0080_0000); // R9 R7
        walk(32'h0080_0FFF, 32'h0001_0000, 3, 1'b1, 32'h0040_3000); // R9 on fault path
        walk(32'h0040_3555, 32'h0001_0000, 1, 1'b0, 32'h0);  // back-to-back R8

        repeat (4) @(negedge clk);
        chk("R1", "idle at end", 32'(req_ready), 32'h1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule